// File: doc/BRIEF.md
# Bounded Temporal Property Monitor

This block is a runtime checker for two sampled Boolean signals, `sig_f` and `sig_g`. After a start pulse it counts clock steps and judges two interval-bounded properties against the trace at once. The first is a bounded until: `sig_g` must appear at some step inside the window `[lo, hi]`, and `sig_f` must hold on every earlier step. The second is a bounded always: `sig_f` must hold on each step of that window. Each verdict is a one-cycle pulse, issued as soon as the outcome is settled. Neither property waits for the other.

The window edges come in on `lo_bound` and `hi_bound` and are captured when a start is accepted. While an evaluation runs, `busy` is high and any further start is dropped. A start that carries `lo_bound > hi_bound` is refused and flagged. Only one evaluation runs at a time. Formulas do not nest.

Top module: `bmon_top`

## Requirements
- R1: A start seen at a clock edge while `busy` is low, with `lo_bound <= hi_bound`, is accepted. `busy` is high from that edge on. The `sig_f`/`sig_g` values sampled at the k-th following edge form step k (the next edge is step 0). The bounds are captured at the accepting edge.
- R2: `until_pass` pulses right after the edge of the first step i with `lo <= i <= hi` and `sig_g` = 1, provided `sig_f` was 1 at every step before i. The value of `sig_f` at step i itself does not matter.
- R3: `until_fail` pulses right after the edge of the first step at which `sig_f` = 0, if no in-window `sig_g` occurred at that step or before it. A `sig_g` that arrives before step `lo` does not end the check.
- R4: `until_fail` pulses right after step `hi` when `sig_f` held and no in-window `sig_g` was seen. The step count never passes `hi` while busy.
- R5: `glob_fail` pulses right after the edge of the first step i in `[lo, hi]` with `sig_f` = 0.
- R6: `glob_pass` pulses right after step `hi` if `sig_f` was 1 at every step in `[lo, hi]`. Values outside the window have no effect.
- R7: A start that arrives while `busy` is high has no effect: no restart, no new bounds, no `cfg_err`.
- R8: Each property gives exactly one verdict per evaluation, as a pulse lasting one cycle. Pass and fail are never high together. `busy` falls in the same cycle that the later of the two verdicts appears.
- R9: A start while idle with `lo_bound > hi_bound` gives a one-cycle `cfg_err` pulse. `busy` stays low and no verdict follows.
- R10: With `rst` high at a clock edge, every output is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one step per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin an evaluation |
| sig_f | input | 1 | Observed signal f |
| sig_g | input | 1 | Observed signal g |
| lo_bound | input | CW | Window start step a |
| hi_bound | input | CW | Window end step b |
| busy | output | 1 | Evaluation in progress |
| until_pass | output | 1 | Bounded-until pass pulse |
| until_fail | output | 1 | Bounded-until fail pulse |
| glob_pass | output | 1 | Bounded-always pass pulse |
| glob_fail | output | 1 | Bounded-always fail pulse |
| cfg_err | output | 1 | Rejected start: lo_bound > hi_bound |

## Verification
Two events can fall in the same cycle: the final verdict that releases `busy`, and a new start request. A start held high on the step edge that settles the last property must be dropped, because `busy` is still high at that edge. A start on the very next edge must be accepted. Directed sequences hold `start` high across the release. Long random runs with frequent starts and narrow windows (including `lo = hi = 0`) also produce the overlap. A behavioural step-count model in the bench judges every output on every cycle.

// File: rtl/bmon_pkg.sv
package bmon_pkg;

    localparam int STEP_WMAX = 16;

    typedef enum logic [1:0] {
        VD_NONE = 2'd0,
        VD_PASS = 2'd1,
        VD_FAIL = 2'd2
    } verdict_e;

    typedef struct packed {
        logic f;
        logic g;
    } sample_t;

    // Bounded until at one step: an in-window g wins, then f dropping, then window end.
    function automatic verdict_e until_rule(input logic [STEP_WMAX-1:0] step,
                                            input logic [STEP_WMAX-1:0] lo,
                                            input logic [STEP_WMAX-1:0] hi,
                                            input sample_t s);
        verdict_e v;
        v = VD_NONE;
        if (step >= lo && s.g)
            v = VD_PASS;
        else if (!s.f)
            v = VD_FAIL;
        else if (step == hi)
            v = VD_FAIL;
        return v;
    endfunction

    // Bounded always at one step: any in-window f low fails, window end passes.
    function automatic verdict_e glob_rule(input logic [STEP_WMAX-1:0] step,
                                           input logic [STEP_WMAX-1:0] lo,
                                           input logic [STEP_WMAX-1:0] hi,
                                           input sample_t s);
        verdict_e v;
        v = VD_NONE;
        if (step >= lo && !s.f)
            v = VD_FAIL;
        else if (step == hi)
            v = VD_PASS;
        return v;
    endfunction

endpackage

// File: rtl/bmon_step_ctr.sv
module bmon_step_ctr #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          run,
    input  logic [CW-1:0] lo_i,
    input  logic [CW-1:0] hi_i,
    output logic [CW-1:0] step_o,
    output logic [CW-1:0] lo_o,
    output logic [CW-1:0] hi_o
);
    localparam logic [CW-1:0] STEP_MAX = {CW{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            step_o <= '0;
            lo_o   <= '0;
            hi_o   <= '0;
        end else if (load) begin
            step_o <= '0;
            lo_o   <= lo_i;
            hi_o   <= hi_i;
        end else if (run && step_o != STEP_MAX) begin
            step_o <= step_o + 1'b1;
        end
    end

    // R1: a load always restarts counting from step zero
    p_load_zero_r1: assert property (@(posedge clk) disable iff (rst)
        load |=> (step_o == '0));
endmodule

// File: rtl/bmon_prop.sv
module bmon_prop
    import bmon_pkg::*;
#(
    parameter int CW       = 6,
    parameter bit IS_UNTIL = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic          active,
    input  logic [CW-1:0] step,
    input  logic [CW-1:0] lo,
    input  logic [CW-1:0] hi,
    input  sample_t       smp,
    output logic          pass_o,
    output logic          fail_o,
    output logic          done_o,
    output logic          decide_o
);
    verdict_e vd;

    generate
        if (IS_UNTIL) begin : g_until
            assign vd = until_rule(STEP_WMAX'(step), STEP_WMAX'(lo), STEP_WMAX'(hi), smp);
        end else begin : g_glob
            assign vd = glob_rule(STEP_WMAX'(step), STEP_WMAX'(lo), STEP_WMAX'(hi), smp);
        end
    endgenerate

    assign decide_o = active && !done_o && (vd != VD_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            pass_o <= 1'b0;
            fail_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            pass_o <= 1'b0;
            fail_o <= 1'b0;
            if (arm) begin
                done_o <= 1'b0;
            end else if (decide_o) begin
                done_o <= 1'b1;
                pass_o <= (vd == VD_PASS);
                fail_o <= (vd == VD_FAIL);
            end
        end
    end

    // R8: never both verdicts at once
    p_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(pass_o && fail_o));
    // R8: a verdict lasts a single cycle
    p_single_r8: assert property (@(posedge clk) disable iff (rst)
        (pass_o || fail_o) |=> !(pass_o || fail_o));
endmodule

// File: rtl/bmon_top.sv
module bmon_top
    import bmon_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          sig_f,
    input  logic          sig_g,
    input  logic [CW-1:0] lo_bound,
    input  logic [CW-1:0] hi_bound,
    output logic          busy,
    output logic          until_pass,
    output logic          until_fail,
    output logic          glob_pass,
    output logic          glob_fail,
    output logic          cfg_err
);
    localparam int NPROP = 2;

    logic          accept, reject, all_done;
    logic [CW-1:0] step_q, lo_q, hi_q;
    logic [NPROP-1:0] pass_v, fail_v, done_v, dec_v;
    sample_t       smp;

    assign smp.f  = sig_f;
    assign smp.g  = sig_g;
    assign accept = start && !busy && (lo_bound <= hi_bound);
    assign reject = start && !busy && (lo_bound >  hi_bound);
    assign all_done = &(done_v | dec_v);

    bmon_step_ctr #(.CW(CW)) u_ctr (
        .clk(clk), .rst(rst), .load(accept), .run(busy),
        .lo_i(lo_bound), .hi_i(hi_bound),
        .step_o(step_q), .lo_o(lo_q), .hi_o(hi_q)
    );

    // Slot 0 judges bounded until, slot 1 bounded always.
    generate
        for (genvar k = 0; k < NPROP; k++) begin : g_prop
            bmon_prop #(.CW(CW), .IS_UNTIL(k == 0)) u_prop (
                .clk(clk), .rst(rst), .arm(accept), .active(busy),
                .step(step_q), .lo(lo_q), .hi(hi_q), .smp(smp),
                .pass_o(pass_v[k]), .fail_o(fail_v[k]),
                .done_o(done_v[k]), .decide_o(dec_v[k])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cfg_err <= 1'b0;
        end else begin
            cfg_err <= reject;
            if (accept)
                busy <= 1'b1;
            else if (busy && all_done)
                busy <= 1'b0;
        end
    end

    assign until_pass = pass_v[0];
    assign until_fail = fail_v[0];
    assign glob_pass  = pass_v[1];
    assign glob_fail  = fail_v[1];

    // R9: a refused start never coexists with an evaluation
    p_cfg_idle_r9: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !busy);
    // R7: a start during an evaluation raises no error
    p_busy_start_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> !cfg_err);
    // R4: counting stops at the window end
    p_step_window_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (step_q <= hi_q));
    // R8: verdicts only follow a busy cycle
    p_verdict_src_r8: assert property (@(posedge clk) disable iff (rst)
        (until_pass || until_fail || glob_pass || glob_fail) |-> $past(busy));
    // R8: release coincides with a verdict
    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (until_pass || until_fail || glob_pass || glob_fail));
endmodule

// File: tb/sim_bmon_top.sv
module sim_bmon_top;
    localparam int CW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, f = 1'b0, g = 1'b0;
    logic [CW-1:0] lo = '0, hi = '0;
    logic busy, upass, ufail, gpass, gfail, cerr;

    int errors = 0, checks = 0, cyc = 0;
    bit ready = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    bmon_top #(.CW(CW)) u0 (
        .clk(clk), .rst(rst), .start(start), .sig_f(f), .sig_g(g),
        .lo_bound(lo), .hi_bound(hi),
        .busy(busy), .until_pass(upass), .until_fail(ufail),
        .glob_pass(gpass), .glob_fail(gfail), .cfg_err(cerr)
    );

    // Behavioural model: integers only, updated on each rising edge.
    int  m_step = 0, m_lo = 0, m_hi = 0;
    bit  m_busy = 0, m_ud = 0, m_gd = 0, m_rst = 0;
    bit  e_up = 0, e_uf = 0, e_gp = 0, e_gf = 0, e_cfg = 0;

    always @(posedge clk) begin
        cyc++;
        ready = 1'b1;
        e_up = 0; e_uf = 0; e_gp = 0; e_gf = 0; e_cfg = 0;
        m_rst = rst;
        if (rst) begin
            m_busy = 0;
        end else if (m_busy) begin
            if (!m_ud) begin
                if (m_step >= m_lo && g)      begin e_up = 1; m_ud = 1; end
                else if (!f)                  begin e_uf = 1; m_ud = 1; end
                else if (m_step == m_hi)      begin e_uf = 1; m_ud = 1; end
            end
            if (!m_gd) begin
                if (m_step >= m_lo && !f)     begin e_gf = 1; m_gd = 1; end
                else if (m_step == m_hi)      begin e_gp = 1; m_gd = 1; end
            end
            if (m_ud && m_gd) m_busy = 0;
            else m_step++;
        end else if (start) begin
            if (int'(lo) > int'(hi)) e_cfg = 1;
            else begin
                m_busy = 1; m_step = 0; m_lo = int'(lo); m_hi = int'(hi);
                m_ud = 0; m_gd = 0;
            end
        end
    end

    task automatic chk(input string tag, input logic act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: got %b expected %b", tag, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (ready) begin
            if (m_rst) begin
                chk("R10 busy",       busy,  1'b0);
                chk("R10 until_pass", upass, 1'b0);
                chk("R10 until_fail", ufail, 1'b0);
                chk("R10 glob_pass",  gpass, 1'b0);
                chk("R10 glob_fail",  gfail, 1'b0);
                chk("R10 cfg_err",    cerr,  1'b0);
            end else begin
                chk("R1 R7 R8 busy",  busy,  m_busy);
                chk("R2 until_pass",  upass, e_up);
                chk("R3 R4 until_fail", ufail, e_uf);
                chk("R6 glob_pass",   gpass, e_gp);
                chk("R5 glob_fail",   gfail, e_gf);
                chk("R9 cfg_err",     cerr,  e_cfg);
            end
        end
    end

    task automatic drive(input bit s, input bit vf, input bit vg, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = s; f = vf; g = vg;
        end
    endtask

    task automatic set_win(input int a, input int b);
        @(negedge clk);
        lo = CW'(a); hi = CW'(b);
    endtask

    initial begin
        drive(0, 0, 0, 3);
        @(negedge clk); rst = 1'b0;
        // R2: g at step 3 inside [2,5]
        set_win(2, 5);
        drive(1, 1, 0, 1); drive(0, 1, 0, 3); drive(0, 1, 1, 1); drive(0, 1, 0, 6);
        // R3/R5: early g ignored, f drops at step 2
        drive(1, 1, 0, 1); drive(0, 1, 1, 1); drive(0, 1, 0, 1); drive(0, 0, 0, 1); drive(0, 1, 0, 6);
        // R4/R6: no g at all
        drive(1, 1, 0, 1); drive(0, 1, 0, 9);
        // R2 precedence: g and f low together at step a
        drive(1, 1, 0, 1); drive(0, 1, 0, 2); drive(0, 0, 1, 1); drive(0, 1, 0, 6);
        // single-step window and start held across release (R7, R8)
        set_win(0, 0);
        drive(1, 1, 1, 6); drive(1, 0, 0, 4); drive(0, 1, 0, 2);
        // R9: reversed bounds
        set_win(4, 1);
        drive(1, 1, 1, 1); drive(0, 1, 1, 3); drive(1, 1, 1, 2); drive(0, 1, 1, 2);
        // R7: starts while busy with new bounds
        set_win(3, 8);
        drive(1, 1, 0, 1); lo = CW'(0); hi = CW'(1); drive(1, 1, 0, 4); drive(0, 1, 0, 8);
        // random phase
        for (int n = 0; n < 6000; n++) begin
            @(negedge clk);
            start = ($urandom_range(0, 3) == 0);
            f = ($urandom_range(0, 9) != 0);
            g = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 7) == 0) begin
                lo = CW'($urandom_range(0, 6));
                hi = CW'($urandom_range(0, 9));
            end
        end
        drive(0, 1, 0, 20);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule